// File: doc/BRIEF.md
# Fall-Through Audio Sample FIFO Port

This block is the data port of a multimedia serial controller for 12-bit audio samples. It holds two fall-through FIFOs behind a small register port. Software writes samples into the transmit FIFO, and the serial transmit logic takes them from the bottom. The serial receive logic pushes samples into the receive FIFO, and software reads them from the bottom. Samples sit left-justified in a 16-bit word. Software shifts them into place before a write and shifts them back after a read.

Every FIFO entry is a register stage with its own valid flag. A new value enters the top stage. It then moves down one stage per clock until it reaches the lowest stage that holds nothing. An entry moves in a given cycle only when the stage below it is empty, or when that stage is being emptied in the same cycle. This lets a full chain advance in one step after a pop.

A control word holds the enable bit and two sticky error flags. While the enable bit is low, both FIFOs are flushed and held empty. The same happens on reset.

Top module: `audio_fifo_port`

Register map: address 0 is the sample data port, and address 1 is the control word. Any other address reads zero and ignores writes. A read updates `rdata` at the clock edge where `rd_en` is sampled high. `rdata` keeps its value while no read is requested.

## Requirements
- R1: A write to address 0 queues `{wdata[15:4], 4'b0000}`. The sample's four low bits are forced to zero, and `wdata[31:16]` is ignored.
- R2: A queued transmit sample appears on `tx_data` with `tx_valid` high at most DEPTH-1 cycles after it is accepted. Samples leave in the order they were written.
- R3: A `tx_pop` pulse while `tx_valid` is high removes the bottom sample, and the next sample follows. A `tx_pop` while `tx_valid` is low changes nothing.
- R4: A data write is dropped when the top transmit stage is occupied and is not moving down in that cycle. A dropped write sets `tx_overrun` (control bit 1), which stays set until cleared. `tx_not_full` is low exactly when the top transmit stage is occupied.
- R5: A `rx_push` stores `rx_data` in the receive FIFO, and the sample falls to the lowest free stage. `rx_not_empty` is high when the bottom receive stage holds a sample.
- R6: A read of address 0 returns `{16'h0000, bottom receive sample}` on `rdata` after the clock edge, removes that sample, and moves the rest down. `rdata[31:16]` is always zero.
- R7: A read of address 0 while the receive FIFO is empty returns zero and sets `rx_underrun` (control bit 2), which stays set until cleared.
- R8: After reset both FIFOs are empty, the enable bit and both flags are zero, and `rdata` is zero.
- R9: While the enable bit (control bit 0) is zero, both FIFOs are emptied within one cycle and stay empty. Data writes and `rx_push` have no effect.
- R10: A read of address 1 returns `{29'b0, rx_underrun, tx_overrun, enable}`. A write to address 1 loads the enable bit from `wdata[0]`, and writing a 1 to bit 1 or bit 2 clears the matching flag. Other addresses read zero, and writes to them have no effect.
- R11: A `rx_push` while the top receive stage is occupied and not moving is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register address (0 data, 1 control) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| tx_pop | input | 1 | Serial transmit logic takes the bottom sample |
| tx_data | output | 16 | Bottom transmit sample (zero when empty) |
| tx_valid | output | 1 | Bottom transmit stage holds a sample |
| tx_not_full | output | 1 | Top transmit stage is free |
| rx_push | input | 1 | Serial receive logic delivers a sample |
| rx_data | input | 16 | Received sample |
| rx_not_empty | output | 1 | Bottom receive stage holds a sample |
| tx_overrun | output | 1 | Sticky: a data write was dropped |
| rx_underrun | output | 1 | Sticky: a data read found the receive FIFO empty |

## Verification
The bench builds the block with DEPTH set to 4 instead of the default 8. With that setting, a few directed writes or pushes fill a FIFO completely. This makes it practical to test the full-top drop, the overrun flag, and a burst of reads that runs past the last sample into underrun. Fall-through settling takes three cycles at this depth, so each scenario can wait a short fixed time and then check ordering and flushing at the ports.

// File: rtl/audio_fifo_pkg.sv
// Shared constants for the audio sample FIFO port.
// Assumes a 16-bit sample word on a 32-bit register bus.
package audio_fifo_pkg;
    localparam int SAMPLE_W = 16;
    localparam int BUS_W    = 32;
    localparam int PAD_W    = 4;   // low bits forced to zero on transmit

    // Register addresses
    localparam int ADR_DATA = 0;
    localparam int ADR_CTRL = 1;

    // Control word bit positions
    localparam int CB_EN  = 0;
    localparam int CB_OVR = 1;
    localparam int CB_UDR = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/fall_fifo.sv
// Fall-through FIFO built from a chain of register stages; stage 0 is the bottom.
// A value enters at the top and drops one stage per clock into free space.
// A stage may take from above when it is empty or is being vacated in the same cycle.
// Assumes DEPTH >= 2. flush has priority over every other operation.
module fall_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         push_ok,
    input  logic         pop,
    output logic [W-1:0] bot_data,
    output logic         bot_valid,
    output logic         top_valid
);
    localparam int TOP = DEPTH - 1;

    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] vac;    // stage is emptied this cycle
    logic [DEPTH-1:0] take;   // stage loads from the stage (or push) above
    logic [W-1:0]     mem [DEPTH];
    logic [W-1:0]     src [DEPTH];

    // Ripple the vacate/take decisions upward from the bottom stage.
    always_comb begin
        vac    = '0;
        take   = '0;
        vac[0] = pop & vld[0];
        for (int i = 0; i < DEPTH - 1; i++) begin
            take[i]  = vld[i+1] & (~vld[i] | vac[i]);
            vac[i+1] = take[i];
        end
        take[TOP] = push & (~vld[TOP] | vac[TOP]);
    end

    assign push_ok = take[TOP];

    // Each stage takes its new value from the stage above, or from the push data at the top.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_src
            if (g == TOP) begin : g_top
                assign src[g] = push_data;
            end else begin : g_mid
                assign src[g] = mem[g+1];
            end
        end
    endgenerate

    // Per-stage storage: flush clears, a take loads, a vacate frees.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[g] <= 1'b0;
                    mem[g] <= '0;
                end else if (flush) begin
                    vld[g] <= 1'b0;
                end else if (take[g]) begin
                    vld[g] <= 1'b1;
                    mem[g] <= src[g];
                end else if (vac[g]) begin
                    vld[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign bot_valid = vld[0];
    assign bot_data  = vld[0] ? mem[0] : '0;
    assign top_valid = vld[TOP];
endmodule

// File: rtl/port_regs.sv
// Register port: decodes the address, drives FIFO push and pop strobes,
// holds the enable bit and the sticky error flags, and registers read data.
// Assumes single-cycle strobes; a read and a write in the same cycle are independent.
module port_regs
    import audio_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    input  logic [SAMPLE_W-1:0] rx_bot_data,
    input  logic                rx_bot_valid,
    output logic                rx_pop,
    output logic                tx_push,
    output logic [SAMPLE_W-1:0] tx_push_data,
    input  logic                tx_push_ok,
    output logic                en,
    output logic                ovr,
    output logic                udr
);
    reg_sel_e sel;
    logic     wr_ctrl;
    logic     ovr_set;
    logic     udr_set;

    // Map the address onto one of the register slots.
    always_comb begin
        if (addr == ADDR_W'(ADR_DATA))      sel = SEL_DATA;
        else if (addr == ADDR_W'(ADR_CTRL)) sel = SEL_CTRL;
        else                                sel = SEL_NONE;
    end

    assign wr_ctrl      = wr_en & (sel == SEL_CTRL);
    assign tx_push      = wr_en & (sel == SEL_DATA) & en;
    assign tx_push_data = {wdata[SAMPLE_W-1:PAD_W], {PAD_W{1'b0}}};
    assign rx_pop       = rd_en & (sel == SEL_DATA);
    assign ovr_set      = tx_push & ~tx_push_ok;
    assign udr_set      = rx_pop & ~rx_bot_valid;

    // Control word: enable is loaded, flags are set by events and cleared by a written 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            ovr <= 1'b0;
            udr <= 1'b0;
        end else begin
            if (wr_ctrl) en <= wdata[CB_EN];
            ovr <= ovr_set | (ovr & ~(wr_ctrl & wdata[CB_OVR]));
            udr <= udr_set | (udr & ~(wr_ctrl & wdata[CB_UDR]));
        end
    end

    // Read data register, updated only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata <= {{(BUS_W-SAMPLE_W){1'b0}}, rx_bot_data};
                SEL_CTRL: rdata <= {{(BUS_W-3){1'b0}}, udr, ovr, en};
                default:  rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/audio_fifo_port.sv
// Top of the audio sample data port: one register port and two fall-through FIFOs.
// Transmit FIFO is filled by bus writes and drained by the serial side;
// receive FIFO is filled by the serial side and drained by bus reads.
// Clearing the enable bit holds both FIFOs empty.
module audio_fifo_port
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rdata,
    input  logic                tx_pop,
    output logic [SAMPLE_W-1:0] tx_data,
    output logic                tx_valid,
    output logic                tx_not_full,
    input  logic                rx_push,
    input  logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_not_empty,
    output logic                tx_overrun,
    output logic                rx_underrun
);
    logic                ctl_en;
    logic                fifo_flush;
    logic                tx_push;
    logic                tx_push_ok;
    logic [SAMPLE_W-1:0] tx_push_data;
    logic                tx_top_valid;
    logic                rx_pop;
    logic [SAMPLE_W-1:0] rx_bot_data;
    logic                rx_bot_valid;
    logic                rx_top_valid;
    logic                rx_push_ok;

    assign fifo_flush = ~ctl_en;

    port_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr         (addr),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .wdata        (wdata),
        .rdata        (rdata),
        .rx_bot_data  (rx_bot_data),
        .rx_bot_valid (rx_bot_valid),
        .rx_pop       (rx_pop),
        .tx_push      (tx_push),
        .tx_push_data (tx_push_data),
        .tx_push_ok   (tx_push_ok),
        .en           (ctl_en),
        .ovr          (tx_overrun),
        .udr          (rx_underrun)
    );

    fall_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (tx_push),
        .push_data (tx_push_data),
        .push_ok   (tx_push_ok),
        .pop       (tx_pop),
        .bot_data  (tx_data),
        .bot_valid (tx_valid),
        .top_valid (tx_top_valid)
    );

    fall_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (rx_push),
        .push_data (rx_data),
        .push_ok   (rx_push_ok),
        .pop       (rx_pop),
        .bot_data  (rx_bot_data),
        .bot_valid (rx_bot_valid),
        .top_valid (rx_top_valid)
    );

    assign tx_not_full  = ~tx_top_valid;
    assign rx_not_empty = rx_bot_valid;
endmodule

// File: rtl/audio_fifo_port_chk.sv
// Property checker for audio_fifo_port, bound into every instance of the top.
// Watches ports and the internal enable bit.
module audio_fifo_port_chk
    import audio_fifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                wr_en,
    input logic                rd_en,
    input logic [BUS_W-1:0]    wdata,
    input logic [BUS_W-1:0]    rdata,
    input logic [SAMPLE_W-1:0] tx_data,
    input logic                tx_valid,
    input logic                rx_not_empty,
    input logic                tx_overrun,
    input logic                rx_underrun,
    input logic                ctl_en
);
    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (!tx_valid && !rx_not_empty));

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_overrun && !(wr_en && addr == ADDR_W'(ADR_CTRL) && wdata[CB_OVR])) |=> tx_overrun);

    // R7
    udr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(ADR_DATA) && !rx_not_empty) |=> (rdata == '0 && rx_underrun));

    // R6
    rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:SAMPLE_W] == '0);

    // R1
    tx_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_data[PAD_W-1:0] == '0);
endmodule

bind audio_fifo_port audio_fifo_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .wdata        (wdata),
    .rdata        (rdata),
    .tx_data      (tx_data),
    .tx_valid     (tx_valid),
    .rx_not_empty (rx_not_empty),
    .tx_overrun   (tx_overrun),
    .rx_underrun  (rx_underrun),
    .ctl_en       (ctl_en)
);

// File: tb/audio_fifo_port_bench.sv
`timescale 1ns/1ps
module audio_fifo_port_bench;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tx_pop = 1'b0;
    logic [15:0] tx_data;
    logic        tx_valid;
    logic        tx_not_full;
    logic        rx_push = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_not_empty;
    logic        tx_overrun;
    logic        rx_underrun;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    audio_fifo_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_audio_fifo_port (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wr_en (wr_en), .rd_en (rd_en),
        .wdata (wdata), .rdata (rdata), .tx_pop (tx_pop), .tx_data (tx_data),
        .tx_valid (tx_valid), .tx_not_full (tx_not_full), .rx_push (rx_push),
        .rx_data (rx_data), .rx_not_empty (rx_not_empty), .tx_overrun (tx_overrun),
        .rx_underrun (rx_underrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (DEPTH + 2) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic do_pop();
        @(negedge clk); tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic do_push(input logic [15:0] d);
        @(negedge clk); rx_data = d; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        chk("R8 rdata", rdata, 32'h0);
        chk("R8 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R8 tx_not_full", {31'b0, tx_not_full}, 32'h1);
        chk("R8 rx_not_empty", {31'b0, rx_not_empty}, 32'h0);
        chk("R8 flags", {30'b0, rx_underrun, tx_overrun}, 32'h0);
        bus_read(4'h1, r);
        chk("R10 ctrl after reset", r, 32'h0);
        bus_write(4'h1, 32'h1);
        bus_read(4'h1, r);
        chk("R10 enable readback", r, 32'h1);
    endtask

    task automatic t_tx_nibble();
        bus_write(4'h0, 32'hFFFF_ABCD);
        repeat (DEPTH - 1) @(negedge clk);
        chk("R2 tx_valid after fall", {31'b0, tx_valid}, 32'h1);
        chk("R1 nibble forced", {16'b0, tx_data}, 32'h0000_ABC0);
        do_pop();
        chk("R3 pop empties", {31'b0, tx_valid}, 32'h0);
    endtask

    task automatic t_tx_fill();
        logic [31:0] r;
        for (int i = 0; i < DEPTH; i++) begin
            bus_write(4'h0, 32'h1000 * (i + 1) + 32'h0005);
            settle();
        end
        chk("R4 not_full low when full", {31'b0, tx_not_full}, 32'h0);
        chk("R4 no overrun yet", {31'b0, tx_overrun}, 32'h0);
        bus_write(4'h0, 32'h0000_EEE0);
        chk("R4 overrun set", {31'b0, tx_overrun}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 order", {16'b0, tx_data}, 32'h1000 * (i + 1));
            do_pop();
            settle();
        end
        chk("R4 dropped write absent", {31'b0, tx_valid}, 32'h0);
        chk("R4 not_full after drain", {31'b0, tx_not_full}, 32'h1);
        do_pop();
        settle();
        chk("R3 pop on empty", {31'b0, tx_valid}, 32'h0);
        chk("R4 overrun sticky", {31'b0, tx_overrun}, 32'h1);
        bus_write(4'h1, 32'h3);
        bus_read(4'h1, r);
        chk("R10 overrun cleared", r, 32'h1);
    endtask

    task automatic t_rx_flow();
        logic [31:0] r;
        for (int i = 0; i < DEPTH + 1; i++) begin
            do_push(16'h0A00 + 16'(i) * 16'h0110);
            settle();
        end
        chk("R5 rx_not_empty", {31'b0, rx_not_empty}, 32'h1);
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(4'h0, r);
            chk("R6 rx read order", r, 32'h0A00 + i * 32'h0110);
            settle();
        end
        chk("R11 extra push dropped", {31'b0, rx_not_empty}, 32'h0);
        chk("R7 no underrun yet", {31'b0, rx_underrun}, 32'h0);
        bus_read(4'h0, r);
        chk("R7 empty read zero", r, 32'h0);
        chk("R7 underrun set", {31'b0, rx_underrun}, 32'h1);
        bus_write(4'h1, 32'h5);
        bus_read(4'h1, r);
        chk("R10 underrun cleared", r, 32'h1);
    endtask

    task automatic t_disable();
        logic [31:0] r;
        do_push(16'h5550);
        bus_write(4'h0, 32'h6660);
        settle();
        chk("R5 rx present before disable", {31'b0, rx_not_empty}, 32'h1);
        chk("R2 tx present before disable", {31'b0, tx_valid}, 32'h1);
        bus_write(4'h1, 32'h0);
        @(negedge clk);
        chk("R9 tx flushed", {31'b0, tx_valid}, 32'h0);
        chk("R9 rx flushed", {31'b0, rx_not_empty}, 32'h0);
        bus_write(4'h0, 32'h7770);
        do_push(16'h8880);
        settle();
        chk("R9 tx write ignored", {31'b0, tx_valid}, 32'h0);
        chk("R9 rx push ignored", {31'b0, rx_not_empty}, 32'h0);
        bus_write(4'h1, 32'h1);
        bus_read(4'h0, r);
        chk("R9 nothing kept after re-enable", r, 32'h0);
        bus_write(4'h1, 32'h5);
    endtask

    task automatic t_unused_addr();
        logic [31:0] r;
        bus_write(4'h7, 32'hFFFF_FFFF);
        settle();
        chk("R10 unused write no push", {31'b0, tx_valid}, 32'h0);
        bus_read(4'h1, r);
        chk("R10 ctrl untouched", r, 32'h1);
        bus_read(4'h7, r);
        chk("R10 unused reads zero", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_nibble();
        t_tx_fill();
        t_rx_flow();
        t_disable();
        t_unused_addr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule